// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block decides which pending interrupt group a small microcontroller core services next. Ten raw event flags are folded into seven source groups. Each group's nesting level, 0 to 3, comes from one bit in a low-weight priority vector and one bit in a high-weight priority vector. A global enable and one enable per group gate the requests. The arbiter reports whether a request stands, the index of the winning group and the level that would be entered.

The core accepts a request by pulsing `take` while `irq_req` is high. This sets the in-service bit of the granted level. A return pulse on `reti` clears the highest in-service bit. A new request is raised only when it would preempt everything currently in service. Build-time parameters drop the serial-peripheral flag, the timer 2 group, the comparator group or the whole high-weight priority vector. When the high-weight vector is dropped, only levels 0 and 1 remain.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, no level is in service, so an enabled, pending group at level 0 produces a request at once.
- R2: A group's level is its `lvl_lo` bit plus twice its `lvl_hi` bit. Bit g of both vectors belongs to group g, and `irq_lvl` reports the winner's level.
- R3: `en_reg[7]` low blocks every request. Bits 0 to 6 of `en_reg` enable groups 0 to 6 one by one, and a group whose bit is low never requests.
- R4: Flag bits map to groups as follows. Bit 0 goes to group 0 (external 0), bit 1 to group 1 (timer 0), bit 2 to group 2 (external 1) and bit 3 to group 3 (timer 1). Bits 4 (receive), 5 (transmit) and 6 (serial-peripheral done) go to group 4 (serial). Bits 7 (overflow) and 8 (external reload) go to group 5 (timer 2). Bit 9 goes to group 6 (comparator).
- R5: The highest level among the requesting groups wins. Among groups at that level, the lowest group index wins, and `irq_vec` carries that index (0 to 6).
- R6: `irq_req` is high only if a group is requesting and its level is strictly above the highest level in service. A request at a level equal to or below the highest in-service level stays silent.
- R7: `take` while `irq_req` is high sets the in-service bit of `irq_lvl` at the clock edge. `take` while `irq_req` is low changes nothing.
- R8: `reti` clears only the highest in-service bit and leaves the lower ones set. With nothing in service it has no effect.
- R9: With `HAS_SPI`=0, flag bit 6 is ignored. With `HAS_T2`=0, group 5 never requests, and with `HAS_CMP`=0, group 6 never requests. With `HAS_HI`=0, `lvl_hi` is ignored and every level is 0 or 1.
- R10: When `reti` and an accepted `take` happen in the same cycle, the highest old bit is cleared first and then the new level's bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_flags | input | 10 | Raw pending event flags (mapping in R4) |
| en_reg | input | 8 | Bit 7 global enable, bits 0..6 group enables |
| lvl_lo | input | 7 | Low-weight priority bit per group |
| lvl_hi | input | 7 | High-weight priority bit per group |
| take | input | 1 | Core accepts the current request |
| reti | input | 1 | Return from the current handler |
| irq_req | output | 1 | A preempting request stands |
| irq_vec | output | 3 | Index of the winning group |
| irq_lvl | output | 2 | Level of the winning group |

## Verification
The in-service stack is the only state in this block. A wrong bit in it shows at the ports one clock after the `take` or `reti` that caused it. It shows as a request that stays silent when it should preempt, or as a request that appears when it should be blocked. The bench therefore walks a nesting sequence and probes with requests placed exactly at, above and below the expected top level after every edge. The combinational priority path is covered by a table of level, enable and flag patterns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int GRP_N  = 7;
  localparam int LVL_N  = 4;
  localparam int LVL_W  = $clog2(LVL_N);
  localparam int VEC_W  = $clog2(GRP_N);
  localparam int FLAG_N = 10;
  localparam int EN_W   = GRP_N + 1;
  localparam int EN_ALL = GRP_N;

  // flag positions
  localparam int F_EXT0 = 0;
  localparam int F_TMR0 = 1;
  localparam int F_EXT1 = 2;
  localparam int F_TMR1 = 3;
  localparam int F_RX   = 4;
  localparam int F_TX   = 5;
  localparam int F_SPI  = 6;
  localparam int F_T2OV = 7;
  localparam int F_T2EX = 8;
  localparam int F_CMP  = 9;

  // group positions (also tie-break order)
  localparam int G_EXT0 = 0;
  localparam int G_TMR0 = 1;
  localparam int G_EXT1 = 2;
  localparam int G_TMR1 = 3;
  localparam int G_SER  = 4;
  localparam int G_TMR2 = 5;
  localparam int G_CMP  = 6;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_group_merge.sv
module irq_group_merge
  import irq_arb_pkg::*;
#(
  parameter bit HAS_SPI = 1'b1,
  parameter bit HAS_T2  = 1'b1,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic [FLAG_N-1:0] evt_flags,
  input  logic [EN_W-1:0]   en_reg,
  output logic [GRP_N-1:0]  grp_req
);
  logic spi_term;
  logic t2_term;
  logic cmp_term;
  logic [GRP_N-1:0] raw;

  generate
    if (HAS_SPI) begin : g_spi
      assign spi_term = evt_flags[F_SPI];
    end else begin : g_no_spi
      assign spi_term = 1'b0;
    end
    if (HAS_T2) begin : g_t2
      assign t2_term = evt_flags[F_T2OV] | evt_flags[F_T2EX];
    end else begin : g_no_t2
      assign t2_term = 1'b0;
    end
    if (HAS_CMP) begin : g_cmp
      assign cmp_term = evt_flags[F_CMP];
    end else begin : g_no_cmp
      assign cmp_term = 1'b0;
    end
  endgenerate

  always_comb begin
    raw         = '0;
    raw[G_EXT0] = evt_flags[F_EXT0];
    raw[G_TMR0] = evt_flags[F_TMR0];
    raw[G_EXT1] = evt_flags[F_EXT1];
    raw[G_TMR1] = evt_flags[F_TMR1];
    raw[G_SER]  = evt_flags[F_RX] | evt_flags[F_TX] | spi_term;
    raw[G_TMR2] = t2_term;
    raw[G_CMP]  = cmp_term;
  end

  assign grp_req = raw & en_reg[GRP_N-1:0] & {GRP_N{en_reg[EN_ALL]}};
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
#(
  parameter bit HAS_HI = 1'b1
) (
  input  logic [GRP_N-1:0] grp_req,
  input  logic [GRP_N-1:0] lvl_lo,
  input  logic [GRP_N-1:0] lvl_hi,
  output logic             win_any,
  output vec_t             win_vec,
  output lvl_t             win_lvl
);
  logic [GRP_N-1:0] hi_eff;
  logic [GRP_N-1:0] at_lvl [LVL_N];

  generate
    if (HAS_HI) begin : g_hi
      assign hi_eff = lvl_hi;
    end else begin : g_no_hi
      assign hi_eff = '0;
    end
    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
      for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        assign at_lvl[l][g] = grp_req[g] && ({hi_eff[g], lvl_lo[g]} == lvl_t'(l));
      end
    end
  endgenerate

  function automatic vec_t lowest_set(input logic [GRP_N-1:0] m);
    vec_t idx;
    idx = '0;
    for (int i = GRP_N - 1; i >= 0; i--) begin
      if (m[i]) idx = vec_t'(i);
    end
    return idx;
  endfunction

  always_comb begin
    win_any = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (|at_lvl[l]) begin
        win_any = 1'b1;
        win_lvl = lvl_t'(l);
        win_vec = lowest_set(at_lvl[l]);
      end
    end
  end
endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  lvl_t             push_lvl,
  input  logic             pop,
  output logic             svc_any,
  output lvl_t             svc_top
);
  logic [LVL_N-1:0] in_svc;
  logic [LVL_N-1:0] in_svc_nxt;
  logic [LVL_N-1:0] top_oh;
  logic             upd_en;

  always_comb begin
    top_oh  = '0;
    svc_top = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (in_svc[l]) begin
        top_oh  = '0;
        top_oh[l] = 1'b1;
        svc_top = lvl_t'(l);
      end
    end
  end

  assign svc_any = |in_svc;
  assign upd_en  = push | pop;

  always_comb begin
    in_svc_nxt = in_svc;
    if (pop)  in_svc_nxt = in_svc_nxt & ~top_oh;
    if (push) in_svc_nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_svc <= '0;
    else if (upd_en) in_svc <= in_svc_nxt;
  end

  // R7: an accepted request marks its level busy
  a_r7_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> in_svc[$past(push_lvl)]);

  // R8: a lone return removes exactly one level
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && svc_any) |=> ($countones(in_svc) + 1 == $countones($past(in_svc))));

  // R8: a return with nothing in service changes nothing
  a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !svc_any) |=> !svc_any);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter bit HAS_SPI = 1'b1,
  parameter bit HAS_T2  = 1'b1,
  parameter bit HAS_CMP = 1'b1,
  parameter bit HAS_HI  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] evt_flags,
  input  logic [EN_W-1:0]   en_reg,
  input  logic [GRP_N-1:0]  lvl_lo,
  input  logic [GRP_N-1:0]  lvl_hi,
  input  logic              take,
  input  logic              reti,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [LVL_W-1:0]  irq_lvl
);
  logic             rst_sync_n;
  logic [GRP_N-1:0] grp_req;
  logic             win_any;
  vec_t             win_vec;
  lvl_t             win_lvl;
  logic             svc_any;
  lvl_t             svc_top;
  logic             push;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_group_merge #(
    .HAS_SPI (HAS_SPI),
    .HAS_T2  (HAS_T2),
    .HAS_CMP (HAS_CMP)
  ) u_merge (
    .evt_flags (evt_flags),
    .en_reg    (en_reg),
    .grp_req   (grp_req)
  );

  irq_level_pick #(
    .HAS_HI (HAS_HI)
  ) u_pick (
    .grp_req (grp_req),
    .lvl_lo  (lvl_lo),
    .lvl_hi  (lvl_hi),
    .win_any (win_any),
    .win_vec (win_vec),
    .win_lvl (win_lvl)
  );

  assign irq_req = win_any && (!svc_any || (win_lvl > svc_top));
  assign irq_vec = win_vec;
  assign irq_lvl = win_lvl;
  assign push    = take && irq_req;

  irq_service_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (push),
    .push_lvl (win_lvl),
    .pop      (reti),
    .svc_any  (svc_any),
    .svc_top  (svc_top)
  );

  // R3: global enable low silences everything
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_reg[EN_ALL] |-> !irq_req);

  // R5: the reported index names a real group
  a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> (int'(irq_vec) < GRP_N));

  // R6: after acceptance, nothing at or below that level may request next cycle
  a_r6_no_equal_preempt: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push && !reti) |=> !(irq_req && (irq_lvl <= $past(irq_lvl))));

  generate
    if (!HAS_HI) begin : g_chk_two_lvl
      // R9: without the high-weight vector only two levels exist
      a_r9_two_levels: assert property (@(posedge clk) disable iff (!rst_sync_n)
        irq_req |-> (irq_lvl <= lvl_t'(1)));
    end
  endgenerate
endmodule

// File: tb/irq_level_arbiter_test.sv
`timescale 1ns/1ps
module irq_level_arbiter_test;
  logic       clk;
  logic       rst_n;
  logic [9:0] evt_flags;
  logic [7:0] en_reg;
  logic [6:0] lvl_lo;
  logic [6:0] lvl_hi;
  logic       take;
  logic       reti;
  logic       irq_req, m_req;
  logic [2:0] irq_vec, m_vec;
  logic [1:0] irq_lvl, m_lvl;

  int total;
  int bad;
  bit done;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .evt_flags(evt_flags), .en_reg(en_reg),
    .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .take(take), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  irq_level_arbiter #(.HAS_SPI(1'b0), .HAS_T2(1'b0), .HAS_CMP(1'b0), .HAS_HI(1'b0)) uut_min (
    .clk(clk), .rst_n(rst_n), .evt_flags(evt_flags), .en_reg(en_reg),
    .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .take(take), .reti(reti),
    .irq_req(m_req), .irq_vec(m_vec), .irq_lvl(m_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0] en;
    logic [6:0] lo;
    logic [6:0] hi;
    logic [9:0] fl;
    logic       req;
    logic [2:0] vec;
    logic [1:0] lvl;
  } row_t;

  localparam int ROWS = 14;
  localparam row_t TBL [ROWS] = '{
    '{8'hFF, 7'h00, 7'h00, 10'h000, 1'b0, 3'd0, 2'd0}, // R6 nothing pending
    '{8'hFF, 7'h00, 7'h00, 10'h00A, 1'b1, 3'd1, 2'd0}, // R5 tie, lower index
    '{8'hFF, 7'h08, 7'h00, 10'h00A, 1'b1, 3'd3, 2'd1}, // R2 low bit lifts group 3
    '{8'hFF, 7'h08, 7'h04, 10'h00C, 1'b1, 3'd2, 2'd2}, // R2 high bit weighs two
    '{8'hFF, 7'h41, 7'h40, 10'h201, 1'b1, 3'd6, 2'd3}, // R5 level beats index
    '{8'h7F, 7'h00, 7'h00, 10'h3FF, 1'b0, 3'd0, 2'd0}, // R3 global off
    '{8'hFE, 7'h00, 7'h00, 10'h005, 1'b1, 3'd2, 2'd0}, // R3 group 0 disabled
    '{8'hFF, 7'h00, 7'h00, 10'h040, 1'b1, 3'd4, 2'd0}, // R4 spi done
    '{8'hFF, 7'h00, 7'h00, 10'h020, 1'b1, 3'd4, 2'd0}, // R4 transmit
    '{8'hFF, 7'h00, 7'h00, 10'h100, 1'b1, 3'd5, 2'd0}, // R4 timer2 reload
    '{8'hDF, 7'h00, 7'h00, 10'h080, 1'b0, 3'd0, 2'd0}, // R3 timer2 disabled
    '{8'hBF, 7'h00, 7'h00, 10'h200, 1'b0, 3'd0, 2'd0}, // R3 comparator disabled
    '{8'hFF, 7'h20, 7'h00, 10'h090, 1'b1, 3'd5, 2'd1}, // R4 receive vs timer2 ovf
    '{8'hFF, 7'h01, 7'h10, 10'h011, 1'b1, 3'd4, 2'd2}  // R2 serial at level 2
  };

  task automatic drive(input logic [7:0] en, input logic [6:0] lo,
                       input logic [6:0] hi, input logic [9:0] fl);
    @(negedge clk);
    en_reg = en; lvl_lo = lo; lvl_hi = hi; evt_flags = fl;
    #1;
  endtask

  task automatic check(input string tag, input logic req, input logic rq,
                       input logic [2:0] vc, input logic [1:0] lv,
                       input logic [2:0] evc, input logic [1:0] elv);
    total++;
    if (req !== rq || (rq && (vc !== evc || lv !== elv))) begin
      bad++;
      $display("FAIL %s: req=%0b vec=%0d lvl=%0d expected req=%0b vec=%0d lvl=%0d",
               tag, req, vc, lv, rq, evc, elv);
    end
  endtask

  task automatic pulse(input logic tk, input logic rt);
    @(negedge clk);
    take = tk; reti = rt;
    @(negedge clk);
    take = 1'b0; reti = 1'b0;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; take = 1'b0; reti = 1'b0;
    evt_flags = '0; en_reg = '0; lvl_lo = '0; lvl_hi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset leaves nothing in service
    drive(8'hFF, 7'h00, 7'h00, 10'h001);
    check("R1 reset state", irq_req, 1'b1, irq_vec, irq_lvl, 3'd0, 2'd0);

    for (int i = 0; i < ROWS; i++) begin
      drive(TBL[i].en, TBL[i].lo, TBL[i].hi, TBL[i].fl);
      check($sformatf("R2/R3/R4/R5 table row %0d", i), irq_req, TBL[i].req,
            irq_vec, irq_lvl, TBL[i].vec, TBL[i].lvl);
    end

    // R9: reduced build
    drive(8'hFF, 7'h00, 7'h00, 10'h040);
    check("R9 spi ignored", m_req, 1'b0, m_vec, m_lvl, 3'd0, 2'd0);
    drive(8'hFF, 7'h00, 7'h00, 10'h180);
    check("R9 timer2 absent", m_req, 1'b0, m_vec, m_lvl, 3'd0, 2'd0);
    drive(8'hFF, 7'h00, 7'h00, 10'h200);
    check("R9 comparator absent", m_req, 1'b0, m_vec, m_lvl, 3'd0, 2'd0);
    drive(8'hFF, 7'h00, 7'h02, 10'h003);
    check("R9 high vector ignored", m_req, 1'b1, m_vec, m_lvl, 3'd0, 2'd0);
    check("R9 full build uses high vector", irq_req, 1'b1, irq_vec, irq_lvl, 3'd1, 2'd2);

    // R7: take with no request is ignored
    drive(8'hFF, 7'h00, 7'h00, 10'h000);
    pulse(1'b1, 1'b0);
    drive(8'hFF, 7'h00, 7'h00, 10'h001);
    check("R7 idle take ignored", irq_req, 1'b1, irq_vec, irq_lvl, 3'd0, 2'd0);

    // R7/R6: nest levels 0, 1, 3
    pulse(1'b1, 1'b0);
    check("R6 equal level blocked", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);
    drive(8'hFF, 7'h02, 7'h00, 10'h003);
    check("R6 higher level preempts", irq_req, 1'b1, irq_vec, irq_lvl, 3'd1, 2'd1);
    pulse(1'b1, 1'b0);
    drive(8'hFF, 7'h04, 7'h04, 10'h004);
    check("R7 level 1 taken, level 3 asks", irq_req, 1'b1, irq_vec, irq_lvl, 3'd2, 2'd3);
    pulse(1'b1, 1'b0);
    drive(8'hFF, 7'h00, 7'h08, 10'h008);
    check("R6 level 2 under level 3 blocked", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);

    // R8: return pops level 3 only
    pulse(1'b0, 1'b1);
    check("R8 pop exposes level 1 top", irq_req, 1'b1, irq_vec, irq_lvl, 3'd3, 2'd2);

    // R10: simultaneous return and take: {0,1} -> {0,2}
    pulse(1'b1, 1'b1);
    check("R10 level 2 now busy", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);
    drive(8'hFF, 7'h02, 7'h00, 10'h002);
    check("R10 level 1 blocked", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);
    pulse(1'b0, 1'b1);
    check("R8 pop leaves level 0 only", irq_req, 1'b1, irq_vec, irq_lvl, 3'd1, 2'd1);
    drive(8'hFF, 7'h00, 7'h00, 10'h001);
    check("R8 level 0 still busy", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);
    pulse(1'b0, 1'b1);
    check("R8 stack empty", irq_req, 1'b1, irq_vec, irq_lvl, 3'd0, 2'd0);
    pulse(1'b0, 1'b1);
    check("R8 empty return no effect", irq_req, 1'b1, irq_vec, irq_lvl, 3'd0, 2'd0);
    pulse(1'b1, 1'b0);
    check("R7 take after empty return", irq_req, 1'b0, irq_vec, irq_lvl, 3'd0, 2'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule